// File: doc/BRIEF.md
# Shared-Space Address Decoder for a Processor Cluster

On a cluster bus shared by up to eight processors, every bus address is decoded to work out where the access lands. The shared space starts at 0x2000000 and is split into 4M-word windows, one per processor ID, in ascending ID order. Each window maps onto that processor's internal memory. The window directly above the last processor is a broadcast region: a write there reaches every processor, the requester included. Addresses outside these windows are left to other decoders.

The requester supplies its own ID with each access. It may write its own window through the shared space, but it may not read it. A read of its own window, or any read of the broadcast region, blocks the target select and sets a sticky error flag. The flag stays set until software pulses a clear input. Target select, offset and broadcast flag are combinational from the request. The error flag is a register that updates on the clock edge after the offending request.

Top module: `mss_addr_dec`

## Requirements
- R1: A valid access to address 0x2000000 + k*0x400000 + o (k = 0..7, o < 0x400000) that is not illegal drives tgt_sel_o with only bit k set, in the same cycle.
- R2: tgt_offset_o equals the address minus its window base (o) whenever any select bit is set, and is 0 when none is set.
- R3: A write by a requester to its own window selects its own bit and leaves the error flag unchanged.
- R4: A read by a requester of its own window drives tgt_sel_o to 0, and the error flag is 1 after the next clock edge.
- R5: A valid write to 0x4000000..0x43FFFFF drives tgt_sel_o to all ones and bcast_o to 1, with the offset taken from 0x4000000.
- R6: A valid read of 0x4000000..0x43FFFFF drives tgt_sel_o to 0 and bcast_o to 0, and sets the error flag after the next clock edge.
- R7: A valid access below 0x2000000 or at or above 0x4400000 gives tgt_sel_o = 0, bcast_o = 0, tgt_offset_o = 0, and leaves the error flag unchanged.
- R8: With req_valid_i low, all outputs except the error flag are 0 and the flag does not change, whatever the address, direction or ID.
- R9: The error flag holds its value until err_clr_i is high at a clock edge, which clears it. If a new illegal access arrives in the same cycle as the clear, the flag stays set.
- R10: While rst_ni is low, the error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access strobe |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_id_i | input | 3 | Requester's own processor ID |
| req_addr_i | input | 32 | Bus address |
| err_clr_i | input | 1 | Clears the sticky error flag |
| tgt_sel_o | output | 8 | Target select, one bit per processor ID |
| tgt_offset_o | output | 22 | Internal offset within the selected window |
| bcast_o | output | 1 | Broadcast write in progress |
| err_o | output | 1 | Sticky illegal-access flag |

## Verification
On every cycle, assertions check four things: an idle strobe gives no select, broadcast always comes with every select bit set, an illegal request forces the flag high on the next edge, and the flag neither drops without a clear nor survives a clear that has no new error with it. The exact window-to-bit mapping, the offset values at window edges, the difference between own-window writes and reads, and the addresses just outside the shared space can only be shown by the bench's directed and random scenarios. The bench compares these against its own arithmetic model on every cycle.

// File: rtl/mss_pkg.sv
package mss_pkg;
  localparam int unsigned MAX_PROCS = 8;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_WIN_BITS = 22;
  localparam logic [31:0] DEF_MMS_BASE = 32'h0200_0000;
endpackage

// File: rtl/mss_region_dec.sv
module mss_region_dec #(
  parameter int unsigned NPROC    = 8,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_BITS = 22,
  parameter logic [ADDR_W-1:0] BASE = 32'h0200_0000,
  localparam int unsigned IDX_W   = $clog2(NPROC + 1)
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                win_hit_o,
  output logic                bc_hit_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [WIN_BITS-1:0] offset_o
);
  localparam int unsigned UP_W = ADDR_W - WIN_BITS;

  logic [ADDR_W-1:0] rel;
  logic [UP_W-1:0]   upper;
  logic              in_space;

  assign rel      = addr_i - BASE;
  assign upper    = rel[ADDR_W-1:WIN_BITS];
  assign in_space = (addr_i >= BASE) && (upper <= UP_W'(NPROC));

  assign idx_o     = upper[IDX_W-1:0];
  assign offset_o  = rel[WIN_BITS-1:0];
  assign bc_hit_o  = in_space && (upper == UP_W'(NPROC));
  assign win_hit_o = in_space && !bc_hit_o;
endmodule

// File: rtl/mss_sel_gen.sv
module mss_sel_gen #(
  parameter int unsigned NPROC = 8,
  parameter int unsigned ID_W  = 3,
  localparam int unsigned IDX_W = $clog2(NPROC + 1)
) (
  input  logic             valid_i,
  input  logic             we_i,
  input  logic [ID_W-1:0]  own_id_i,
  input  logic             win_hit_i,
  input  logic             bc_hit_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [NPROC-1:0] sel_o,
  output logic             bcast_o,
  output logic             illegal_o
);
  logic own_win;
  assign own_win   = win_hit_i && (idx_i == IDX_W'(own_id_i));
  assign illegal_o = valid_i && !we_i && (own_win || bc_hit_i);
  assign bcast_o   = valid_i && we_i && bc_hit_i;

  for (genvar g = 0; g < NPROC; g++) begin : g_sel
    always_comb begin
      sel_o[g] = bcast_o ||
                 (valid_i && win_hit_i && (idx_i == IDX_W'(g)) && (we_i || !own_win));
    end
  end
endmodule

// File: rtl/mss_err_trk.sv
module mss_err_trk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (set_i) err_q <= 1'b1;   // set wins over clear
    else if (clr_i) err_q <= 1'b0;
  end
  assign err_o = err_q;

  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> err_q); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q); // R9
  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !err_q); // R9
  AST_ERR_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_q && !set_i) |=> !err_q); // R7
endmodule

// File: rtl/mss_addr_dec.sv
module mss_addr_dec #(
  parameter int unsigned NPROC    = mss_pkg::MAX_PROCS,
  parameter int unsigned ID_W     = 3,
  parameter int unsigned ADDR_W   = mss_pkg::DEF_ADDR_W,
  parameter int unsigned WIN_BITS = mss_pkg::DEF_WIN_BITS,
  parameter logic [ADDR_W-1:0] BASE = mss_pkg::DEF_MMS_BASE
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_we_i,
  input  logic [ID_W-1:0]     req_id_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic                err_clr_i,
  output logic [NPROC-1:0]    tgt_sel_o,
  output logic [WIN_BITS-1:0] tgt_offset_o,
  output logic                bcast_o,
  output logic                err_o
);
  localparam int unsigned IDX_W = $clog2(NPROC + 1);

  logic                win_hit, bc_hit, illegal;
  logic [IDX_W-1:0]    idx;
  logic [WIN_BITS-1:0] offset;

  mss_region_dec #(.NPROC(NPROC), .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE(BASE)) i_region (
    .addr_i(req_addr_i), .win_hit_o(win_hit), .bc_hit_o(bc_hit),
    .idx_o(idx), .offset_o(offset)
  );

  mss_sel_gen #(.NPROC(NPROC), .ID_W(ID_W)) i_sel (
    .valid_i(req_valid_i), .we_i(req_we_i), .own_id_i(req_id_i),
    .win_hit_i(win_hit), .bc_hit_i(bc_hit), .idx_i(idx),
    .sel_o(tgt_sel_o), .bcast_o(bcast_o), .illegal_o(illegal)
  );

  mss_err_trk i_err (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(illegal), .clr_i(err_clr_i), .err_o(err_o)
  );

  assign tgt_offset_o = (|tgt_sel_o) ? offset : '0;

  AST_IDLE_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (tgt_sel_o == '0 && !bcast_o)); // R8
  AST_BCAST_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_o |-> (&tgt_sel_o)); // R5
  AST_SEL_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bcast_o |-> $onehot0(tgt_sel_o)); // R1
  AST_ILLEGAL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal |-> (tgt_sel_o == '0)); // R4
endmodule

// File: tb/test_mss_addr_dec.sv
module test_mss_addr_dec;
  logic        clk_i = 0, rst_ni = 0;
  logic        req_valid_i = 0, req_we_i = 0, err_clr_i = 0;
  logic [2:0]  req_id_i = 0;
  logic [31:0] req_addr_i = 0;
  logic [7:0]  tgt_sel_o;
  logic [21:0] tgt_offset_o;
  logic        bcast_o, err_o;

  int n_tests = 0, n_fail = 0;
  bit m_err = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  mss_addr_dec i_mss_addr_dec (.*);

  task automatic chk(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, check before next posedge, then update model at posedge
  task automatic cyc(bit v, bit we, int id, longint a, bit clr, string req);
    longint base = 64'h2000000, win = 64'h400000;
    longint e_sel = 0, e_off = 0;
    bit e_bc = 0, e_ill = 0;
    int k;
    @(negedge clk_i);
    req_valid_i = v; req_we_i = we; req_id_i = 3'(id);
    req_addr_i = 32'(a); err_clr_i = clr;
    if (v && a >= base && a < base + 9 * win) begin
      k = int'((a - base) / win);
      if (k == 8) begin
        if (we) begin e_sel = 255; e_bc = 1; e_off = (a - base) % win; end
        else e_ill = 1;
      end else if (!we && k == id) e_ill = 1;
      else begin e_sel = 64'd1 << k; e_off = (a - base) % win; end
    end
    #4;
    chk({req, " sel"}, tgt_sel_o, e_sel);
    chk({req, " off R2"}, tgt_offset_o, e_off);
    chk({req, " bcast"}, bcast_o, e_bc);
    chk({req, " err R9"}, err_o, m_err);
    @(posedge clk_i);
    if (e_ill) m_err = 1;
    else if (clr) m_err = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #3;
    chk("R10 reset err", err_o, 0);
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1;
    cyc(1, 0, 0, 64'h2480000, 0, "R1 id0 reads id1");
    cyc(1, 1, 0, 64'h3000000, 0, "R1 id4 low edge");
    cyc(1, 1, 2, 64'h33FFFFF, 0, "R1 R2 id4 high edge");
    cyc(1, 0, 1, 64'h3C00000, 0, "R1 id7 base");
    cyc(1, 1, 3, 64'h2C01234, 0, "R3 own write");
    cyc(0, 0, 0, 0, 0, "R3 err still clear");
    cyc(1, 0, 3, 64'h2C01234, 0, "R4 own read");
    cyc(0, 0, 0, 0, 0, "R4 err set");
    cyc(0, 0, 0, 0, 0, "R9 sticky");
    cyc(0, 0, 0, 0, 1, "R9 clear");
    cyc(0, 0, 0, 0, 0, "R9 cleared");
    cyc(1, 1, 5, 64'h4000010, 0, "R5 bcast write");
    cyc(1, 1, 0, 64'h43FFFFF, 0, "R5 bcast top");
    cyc(1, 0, 5, 64'h4000010, 1, "R6 R9 bcast read with clear");
    cyc(1, 1, 0, 64'h1FFFFFF, 0, "R6 err set; R7 below");
    cyc(1, 0, 0, 64'h4400000, 1, "R7 above; R9 clear");
    cyc(1, 0, 0, 64'h0, 0, "R7 zero");
    cyc(0, 0, 2, 64'h2800000, 0, "R8 idle own read");
    cyc(0, 1, 0, 64'h4000000, 0, "R8 idle bcast");
    for (int i = 0; i < 400; i++) begin
      longint a;
      a = 64'h1F00000 + longint'($urandom_range(0, 32'h2600000));
      cyc($urandom_range(0, 3) != 0, 1'($urandom), $urandom_range(0, 7), a,
          $urandom_range(0, 5) == 0, "R1 R3 R4 R6 R7 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule